// File: doc/BRIEF.md
# Interrupt Priority Store with Security-Aware Views

This block keeps one 8-bit priority value for each shared interrupt line. It also works out the effective security group of each line from a group bit, a group modifier bit and a global security-disable control. Software reaches the priorities through a simple single-cycle register bus. Each request carries a flag that marks it as secure or non-secure. The stored priorities and the decoded groups leave the block as flat vectors, for use by the selection logic further down the chip.

When security is enabled, a non-secure request gets a restricted view. Lines that are not non-secure group 1 look like zero and cannot be changed. For lines that are non-secure group 1, a read returns the value shifted up by one bit. A write lands in the low-urgency half of the range: the top bit is forced to one and the written value is shifted down by one bit. Secure requests, and every request while security is disabled, see the raw byte.

A request is a word-wide access made of byte lanes. Each lane carries its own write strobe. Each lane is treated as a separate interrupt, with its own group check.

Top module: `prio_store_top`

## Requirements
- R1: Byte lane i of a request at byte address A (the low log2(BUS_BYTES) address bits are treated as zero) addresses interrupt A+i; read data appears on rd_data_o with rd_valid_o high in the cycle after the request, and rd_valid_o is low otherwise.
- R2: After reset every stored priority is 0xAA, and rd_valid_o and rd_data_o are zero.
- R3: With security enabled, a non-secure request to a lane whose interrupt is not non-secure group 1 reads that lane as 0x00 and leaves its priority unchanged on write.
- R4: With security enabled, a non-secure read of a non-secure group 1 interrupt returns the stored byte shifted left by one, truncated to 8 bits, so bit 0 is zero.
- R5: With security enabled, a non-secure write of byte v to a non-secure group 1 interrupt stores 0x80 | (v >> 1).
- R6: Secure requests, and every request while sec_disable_i is high, read and write the raw stored byte.
- R7: Group codes on eff_grp_o (two bits per interrupt, interrupt k at bits 2k+1:2k) are 00 group 0, 01 secure group 1, 10 non-secure group 1; with sec_disable_i high the code is 10 when the group bit is 1 and 00 otherwise.
- R8: With security enabled, group/modifier bits 0/0 give 00, 1/0 give 10, 0/1 give 01, and 1/1 give 10.
- R9: A write changes only the lanes whose strobe bit is set, and each lane passes or fails the group check by itself.
- R10: A lane whose interrupt number is NUM_IRQ or above reads as zero and ignores writes.
- R11: prio_o bits 8k+7:8k carry the stored priority of interrupt k, updated at the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_disable_i | input | 1 | High turns off the two security states |
| grp_bit_i | input | NUM_IRQ | Group bit per interrupt |
| grp_mod_i | input | NUM_IRQ | Group modifier bit per interrupt |
| req_valid_i | input | 1 | Bus request this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_secure_i | input | 1 | Request comes from the secure state |
| req_addr_i | input | ADDR_W | Byte address within the priority range |
| req_wdata_i | input | 8*BUS_BYTES | Write data, one byte per lane |
| req_be_i | input | BUS_BYTES | Per-lane write strobes |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8*BUS_BYTES | Read data, one byte per lane |
| eff_grp_o | output | 2*NUM_IRQ | Effective group code per interrupt |
| prio_o | output | 8*NUM_IRQ | Stored priority per interrupt |

## Verification
The assertions assume that group, modifier and security-disable inputs hold steady around a request. They also assume that a request lasts exactly one cycle, so a blocked or non-secure write can be tied to the next cycle's priority value. The bench changes those configuration inputs only on falling edges, between requests, and drives each request for a single cycle. The stimulus visits all four group/modifier combinations on adjacent lanes of one word. It also covers partial strobes, the top word of the range, and a word past the range.

// File: rtl/prio_store_pkg.sv
package prio_store_pkg;

    localparam logic [1:0] GRP_G0   = 2'b00;
    localparam logic [1:0] GRP_G1S  = 2'b01;
    localparam logic [1:0] GRP_G1NS = 2'b10;

    localparam logic [7:0] PRIO_RESET = 8'hAA;

    // Read view seen by restricted software
    function automatic logic [7:0] ns_read_view(input logic [7:0] raw);
        return {raw[6:0], 1'b0};
    endfunction

    // Store value produced by a restricted write
    function automatic logic [7:0] ns_write_view(input logic [7:0] v);
        return {1'b1, v[7:1]};
    endfunction

endpackage

// File: rtl/prio_grp_decode.sv
module prio_grp_decode
    import prio_store_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sec_disable_i,
    input  logic [NUM_IRQ-1:0]     grp_bit_i,
    input  logic [NUM_IRQ-1:0]     grp_mod_i,
    output logic [2*NUM_IRQ-1:0]   grp_o
);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        logic [1:0] code;

        always_comb begin
            if (sec_disable_i) begin
                code = grp_bit_i[k] ? GRP_G1NS : GRP_G0;
            end else begin
                unique case ({grp_mod_i[k], grp_bit_i[k]})
                    2'b00:   code = GRP_G0;
                    2'b01:   code = GRP_G1NS;
                    2'b10:   code = GRP_G1S;
                    default: code = GRP_G1NS;
                endcase
            end
        end

        assign grp_o[2*k +: 2] = code;

        // R7: no secure group 1 once security is off
        p_no_g1s_when_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sec_disable_i |-> (grp_o[2*k +: 2] != GRP_G1S));

        // R8: only three legal codes
        p_grp_code_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $onehot0(grp_o[2*k +: 2]));
    end

endmodule

// File: rtl/prio_lane_gate.sv
module prio_lane_gate
    import prio_store_pkg::*;
(
    input  logic       req_valid_i,
    input  logic       req_write_i,
    input  logic       req_secure_i,
    input  logic       sec_disable_i,
    input  logic       in_range_i,
    input  logic       strobe_i,
    input  logic [1:0] grp_i,
    input  logic [7:0] stored_i,
    input  logic [7:0] wbyte_i,
    output logic [7:0] rbyte_o,
    output logic       wr_en_o,
    output logic [7:0] wr_byte_o,
    output logic       ns_view_o,
    output logic       blocked_o
);

    logic restricted;
    logic visible;

    always_comb begin
        restricted = !sec_disable_i && !req_secure_i;
        visible    = in_range_i && (!restricted || grp_i == GRP_G1NS);
        ns_view_o  = restricted && visible;
        blocked_o  = req_valid_i && req_write_i && strobe_i && in_range_i && !visible;

        if (!visible) begin
            rbyte_o = 8'h00;
        end else if (restricted) begin
            rbyte_o = ns_read_view(stored_i);
        end else begin
            rbyte_o = stored_i;
        end

        wr_en_o   = req_valid_i && req_write_i && strobe_i && visible;
        wr_byte_o = restricted ? ns_write_view(wbyte_i) : wbyte_i;
    end

endmodule

// File: rtl/prio_store_top.sv
module prio_store_top
    import prio_store_pkg::*;
#(
    parameter int NUM_IRQ   = 32,
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     sec_disable_i,
    input  logic [NUM_IRQ-1:0]       grp_bit_i,
    input  logic [NUM_IRQ-1:0]       grp_mod_i,
    input  logic                     req_valid_i,
    input  logic                     req_write_i,
    input  logic                     req_secure_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [8*BUS_BYTES-1:0]   req_wdata_i,
    input  logic [BUS_BYTES-1:0]     req_be_i,
    output logic                     rd_valid_o,
    output logic [8*BUS_BYTES-1:0]   rd_data_o,
    output logic [2*NUM_IRQ-1:0]     eff_grp_o,
    output logic [8*NUM_IRQ-1:0]     prio_o
);

    localparam int OFF_W  = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 1;
    localparam int SEL_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int DATA_W = 8 * BUS_BYTES;

    typedef struct packed {
        logic [NUM_IRQ-1:0][7:0] prio;
        logic [DATA_W-1:0]       rdata;
        logic                    rvalid;
    } state_t;

    state_t state_d, state_q;

    logic [2*NUM_IRQ-1:0] grp_flat;

    prio_grp_decode #(.NUM_IRQ(NUM_IRQ)) grp_dec_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sec_disable_i (sec_disable_i),
        .grp_bit_i     (grp_bit_i),
        .grp_mod_i     (grp_mod_i),
        .grp_o         (grp_flat)
    );

    // Per-lane addressing and gating
    logic [ADDR_W-1:0]    base_addr;
    logic [BUS_BYTES-1:0][ADDR_W-1:0] lane_idx;
    logic [BUS_BYTES-1:0][SEL_W-1:0]  lane_sel;
    logic [BUS_BYTES-1:0]             lane_in_range;
    logic [BUS_BYTES-1:0][7:0]        lane_rbyte;
    logic [BUS_BYTES-1:0]             lane_wr_en;
    logic [BUS_BYTES-1:0][7:0]        lane_wr_byte;
    logic [BUS_BYTES-1:0]             lane_ns_view;
    logic [BUS_BYTES-1:0]             lane_blocked;

    always_comb begin
        base_addr = req_addr_i;
        if (BUS_BYTES > 1) begin
            base_addr[OFF_W-1:0] = '0;
        end
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        logic [1:0] lane_grp;
        logic [7:0] lane_stored;

        assign lane_idx[i]      = base_addr + ADDR_W'(i);
        assign lane_in_range[i] = (32'(lane_idx[i]) < NUM_IRQ);
        assign lane_sel[i]      = lane_in_range[i] ? lane_idx[i][SEL_W-1:0] : '0;
        assign lane_grp         = grp_flat[2*lane_sel[i] +: 2];
        assign lane_stored      = state_q.prio[lane_sel[i]];

        prio_lane_gate gate_i (
            .req_valid_i   (req_valid_i),
            .req_write_i   (req_write_i),
            .req_secure_i  (req_secure_i),
            .sec_disable_i (sec_disable_i),
            .in_range_i    (lane_in_range[i]),
            .strobe_i      (req_be_i[i]),
            .grp_i         (lane_grp),
            .stored_i      (lane_stored),
            .wbyte_i       (req_wdata_i[8*i +: 8]),
            .rbyte_o       (lane_rbyte[i]),
            .wr_en_o       (lane_wr_en[i]),
            .wr_byte_o     (lane_wr_byte[i]),
            .ns_view_o     (lane_ns_view[i]),
            .blocked_o     (lane_blocked[i])
        );
    end

    // Per-interrupt hit flags used by the checks
    logic [NUM_IRQ-1:0] ns_wr_hit;
    logic [NUM_IRQ-1:0] blocked_hit;

    always_comb begin
        state_d = state_q;
        ns_wr_hit   = '0;
        blocked_hit = '0;

        for (int k = 0; k < NUM_IRQ; k++) begin
            for (int i = 0; i < BUS_BYTES; i++) begin
                if (lane_in_range[i] && 32'(lane_sel[i]) == k) begin
                    if (lane_wr_en[i]) begin
                        state_d.prio[k] = lane_wr_byte[i];
                        if (lane_ns_view[i]) begin
                            ns_wr_hit[k] = 1'b1;
                        end
                    end
                    if (lane_blocked[i]) begin
                        blocked_hit[k] = 1'b1;
                    end
                end
            end
        end

        state_d.rvalid = req_valid_i && !req_write_i;
        state_d.rdata  = state_d.rvalid ? DATA_W'(lane_rbyte) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.prio   <= {NUM_IRQ{PRIO_RESET}};
            state_q.rdata  <= '0;
            state_q.rvalid <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid_o = state_q.rvalid;
    assign rd_data_o  = state_q.rdata;
    assign eff_grp_o  = grp_flat;
    assign prio_o     = state_q.prio;

    // R1: read data only follows a read request
    p_rd_valid_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> $past(req_valid_i && !req_write_i));

    // R1: an idle bus returns no data
    p_rd_zero_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_valid_o |-> (rd_data_o == '0));

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chk
        // R3: a refused write leaves the byte alone
        p_blocked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (blocked_hit[k] && !(|(lane_wr_en & lane_in_range))) |=>
                $stable(prio_o[8*k +: 8]));

        // R5: a restricted write lands in the low-urgency half
        p_ns_store_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ns_wr_hit[k] |=> prio_o[8*k+7]);
    end

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rchk
        logic ns_view_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ns_view_q <= 1'b0;
            else         ns_view_q <= lane_ns_view[i] && req_valid_i && !req_write_i;
        end

        // R4: restricted read view always has a clear bit 0
        p_ns_read_lsb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_valid_o && ns_view_q) |-> (rd_data_o[8*i] == 1'b0));
    end

endmodule

// File: tb/prio_store_top_tb_top.sv
module prio_store_top_tb_top;

    localparam int N  = 32;
    localparam int BB = 4;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sec_dis = 1'b0;
    logic [N-1:0]    grp_bit = '1;
    logic [N-1:0]    grp_mod = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic            req_secure = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic [3:0]      req_be = '0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic [2*N-1:0]  eff_grp;
    logic [8*N-1:0]  prio;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    prio_store_top #(.NUM_IRQ(N), .BUS_BYTES(BB), .ADDR_W(AW)) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .sec_disable_i (sec_dis),
        .grp_bit_i (grp_bit), .grp_mod_i (grp_mod),
        .req_valid_i (req_valid), .req_write_i (req_write),
        .req_secure_i (req_secure), .req_addr_i (req_addr),
        .req_wdata_i (req_wdata), .req_be_i (req_be),
        .rd_valid_o (rd_valid), .rd_data_o (rd_data),
        .eff_grp_o (eff_grp), .prio_o (prio)
    );

    typedef struct packed {
        logic        wr;
        logic        sec;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  be;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Groups: irq0 G0, irq1 G1NS, irq2 G1S, irq3 G1NS(1/1), others G1NS
    localparam vec_t VECS [0:11] = '{
        '{1'b0, 1'b1, 8'd0,  32'h0,        4'h0, 32'hAAAAAAAA, 8'd2},
        '{1'b0, 1'b0, 8'd0,  32'h0,        4'h0, 32'h54005400, 8'd4},
        '{1'b1, 1'b0, 8'd0,  32'h10203040, 4'hF, 32'h0,        8'd5},
        '{1'b0, 1'b1, 8'd0,  32'h0,        4'h0, 32'h88AA98AA, 8'd3},
        '{1'b0, 1'b0, 8'd0,  32'h0,        4'h0, 32'h10003000, 8'd4},
        '{1'b1, 1'b1, 8'd0,  32'h01020304, 4'h5, 32'h0,        8'd9},
        '{1'b0, 1'b1, 8'd2,  32'h0,        4'h0, 32'h88029804, 8'd9},
        '{1'b1, 1'b0, 8'd4,  32'hFFFFFFFF, 4'h2, 32'h0,        8'd9},
        '{1'b0, 1'b1, 8'd4,  32'h0,        4'h0, 32'hAAAAFFAA, 8'd5},
        '{1'b1, 1'b1, 8'd32, 32'h12345678, 4'hF, 32'h0,        8'd10},
        '{1'b0, 1'b1, 8'd32, 32'h0,        4'h0, 32'h00000000, 8'd10},
        '{1'b0, 1'b1, 8'd28, 32'h0,        4'h0, 32'hAAAAAAAA, 8'd10}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic sec, input logic [7:0] addr,
                          input logic [31:0] wd, input logic [3:0] be,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_secure = sec;
        req_addr = addr; req_wdata = wd; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_be = '0;
        rd = rd_data;
        if (!wr) check("R1 rd_valid", 64'(rd_valid), 64'd1);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        grp_bit[0] = 1'b0; grp_mod[0] = 1'b0;
        grp_bit[1] = 1'b1; grp_mod[1] = 1'b0;
        grp_bit[2] = 1'b0; grp_mod[2] = 1'b1;
        grp_bit[3] = 1'b1; grp_mod[3] = 1'b1;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 prio reset", 64'(prio[8*N-1 -: 64]), 64'hAAAAAAAAAAAAAAAA);
        check("R2 prio reset low", 64'(prio[63:0]), 64'hAAAAAAAAAAAAAAAA);
        check("R2 rd_valid", 64'(rd_valid), 64'd0);
        check("R2 rd_data", 64'(rd_data), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 group decode", 64'(eff_grp[7:0]), 64'h98);

        for (int v = 0; v < 12; v++) begin
            access(VECS[v].wr, VECS[v].sec, VECS[v].addr, VECS[v].wdata, VECS[v].be, rd);
            if (!VECS[v].wr)
                check($sformatf("R%0d vector %0d", VECS[v].req, v), 64'(rd), 64'(VECS[v].exp));
        end

        // R11: stored priority visible at the port
        check("R11 prio_o irq1", 64'(prio[15:8]), 64'h98);
        check("R11 prio_o irq5", 64'(prio[47:40]), 64'hFF);

        // R7: security disabled decode
        @(negedge clk);
        sec_dis = 1'b1;
        @(negedge clk);
        check("R7 group decode off", 64'(eff_grp[7:0]), 64'h88);
        // R6: raw view for a non-secure request when security is off
        access(1'b0, 1'b0, 8'd0, 32'h0, 4'h0, rd);
        check("R6 raw read", 64'(rd), 64'h88029804);
        access(1'b1, 1'b0, 8'd0, 32'h00000011, 4'h1, rd);
        check("R6 raw write", 64'(prio[7:0]), 64'h11);
        access(1'b0, 1'b0, 8'd0, 32'h0, 4'h0, rd);
        check("R9 other lanes held", 64'(rd), 64'h88029811);

        // R3: blocked write leaves prio_o unchanged
        sec_dis = 1'b0;
        access(1'b1, 1'b0, 8'd0, 32'h00000077, 4'h1, rd);
        check("R3 blocked write", 64'(prio[7:0]), 64'h11);
        // R10: last interrupt in range still writable
        access(1'b1, 1'b1, 8'd28, 32'h3C000000, 4'h8, rd);
        check("R10 last irq", 64'(prio[8*N-1 -: 8]), 64'h3C);

        @(negedge clk);
        check("R1 idle rd_valid", 64'(rd_valid), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule